// File: doc/BRIEF.md
# Chunked Auxiliary Register Transfer Engine

This block sits between a user that wants to read or write a run of bytes at a 20-bit register address and a lower-level auxiliary channel. The channel can only move a small burst at a time, and any single burst may fail. The user issues one request with a direction, a start address and a byte count. The engine cuts the request into bursts of up to 16 bytes. For each burst it programs the channel's address fields, command word and 16-entry data buffer, starts the channel, and judges the outcome. A failed burst is retried. When a burst succeeds, the address moves past it, and read bytes are handed back in order. Write bytes come in on a valid/ready stream. Read bytes leave on a second valid/ready stream. A one-cycle done pulse with an error flag ends every request.

The controller is a single state machine. IDLE accepts a request and goes to FINISH for a zero count, to GATHER for a write, or to CLEAR for a read. GATHER takes one burst of write bytes into a local staging store and moves to CLEAR after the last byte. CLEAR empties the channel buffer and goes to LOAD (write) or START (read). LOAD copies the staged bytes into the channel buffer, one per cycle, then goes to START. START raises the channel start strobe and moves to WAIT_EN. WAIT_EN waits for the busy flag to drop and moves to WAIT_REPLY, or fails on its timeout. WAIT_REPLY waits for the reply flag, clears it and moves to JUDGE, or fails on its timeout. JUDGE fails the attempt on a set error flag (which it clears) or on a non-zero status. Otherwise it passes to UNLOAD (read) or ADVANCE (write). UNLOAD streams the burst out. ADVANCE steps the address and count and goes to GATHER, CLEAR or FINISH. On any failure the machine returns to CLEAR while tries remain, and goes to FINISH with the error flag once they are spent. FINISH pulses done and returns to IDLE.

Top module: `aux_burst_xfer`

## Requirements
- R1: A request of N bytes is carried out as bursts of min(remaining, 16) bytes. After each successful burst, the address (modulo 2^20) advances and the remaining count falls by that burst's size.
- R2: While a burst is in progress, address bits 7:0, 15:8 and 19:16 of the burst start address appear on `ch_addr_lo`, `ch_addr_mid` and `ch_addr_hi`.
- R3: The command word `ch_cmd` has bits 7:4 equal to burst length minus one, bit 3 set to 1 (native transaction), bits 2:1 set to 0, and bit 0 set to 1 for read and 0 for write.
- R4: Every attempt is preceded by a buffer clear. For a write, the channel buffer at start holds the burst bytes in entries 0..len-1 and zero elsewhere. For a read, the buffer is all zero at start.
- R5: Read bytes are offered on `rd_valid`/`rd_data` only after a successful attempt. They are offered in address order, one per handshake, and are held while `rd_ready` is low.
- R6: An attempt fails if `ch_busy` is still high at the EN_MS-th `tick_ms` pulse after start.
- R7: An attempt fails if `ch_reply` has not risen by the RPLY_MS-th `tick_ms` pulse after busy drops.
- R8: After a reply, a set `ch_err` is cleared with a `ch_err_clr` pulse and fails the attempt.
- R9: After a reply with `ch_err` low, a non-zero `ch_status` fails the attempt.
- R10: Each burst is attempted at most 10 times. If 10 attempts fail, done is given with `xfer_err`=1 and no further attempt or burst is started. Otherwise done comes with `xfer_err`=0.
- R11: Each observed reply is cleared with a `ch_reply_clr` pulse, so the reply flag is low at the next start.
- R12: A zero-length request raises `xfer_done` with `xfer_err`=0 in the cycle after acceptance, with no channel activity.
- R13: `req_ready` is high only when idle. `xfer_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Start register address |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| xfer_done | output | 1 | Request finished (pulse) |
| xfer_err | output | 1 | Request failed, valid with done |
| ch_buf_clr | output | 1 | Clear channel buffer |
| ch_addr_lo | output | 8 | Address bits 7:0 |
| ch_addr_mid | output | 8 | Address bits 15:8 |
| ch_addr_hi | output | 4 | Address bits 19:16 |
| ch_cmd | output | IDX_W+4 | Command word |
| ch_buf_we | output | 1 | Buffer entry write |
| ch_buf_idx | output | IDX_W | Buffer entry index |
| ch_buf_wdata | output | 8 | Buffer write byte |
| ch_buf_rdata | input | 8 | Buffer byte at ch_buf_idx |
| ch_start | output | 1 | Start channel (sets busy) |
| ch_busy | input | 1 | Channel enable bit, self-clears |
| ch_reply | input | 1 | Reply-received flag |
| ch_reply_clr | output | 1 | Clear reply flag |
| ch_err | input | 1 | Access error flag |
| ch_err_clr | output | 1 | Clear error flag |
| ch_status | input | STAT_W | Reply status, zero = good |

## Verification
A zero-length request shows done in the cycle right after the accepting edge. Every other result is tied to a handshake rather than a fixed delay. One cycle after the buffer clear, LOAD writes (for a write) or START strobes (for a read). START follows the last buffer write by one cycle. A timeout moves to CLEAR or FINISH in the cycle after the limiting tick, and a read byte is consumed at the edge after `rd_valid` and `rd_ready` are both high. The bench therefore samples all outputs half a cycle after each edge. It checks each start strobe against the next expected attempt record (address, command, buffer image) and each read handshake against the next expected byte. When done appears, it confirms that no expected attempt or byte remains.

// File: rtl/aux_xfer_pkg.sv
package aux_xfer_pkg;

    localparam int unsigned ADDR_W = 20;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GATHER,
        S_CLEAR,
        S_LOAD,
        S_START,
        S_WAIT_EN,
        S_WAIT_REPLY,
        S_JUDGE,
        S_UNLOAD,
        S_ADVANCE,
        S_FINISH
    } xfer_state_e;

endpackage

// File: rtl/aux_chunk_calc.sv
module aux_chunk_calc #(
    parameter int unsigned LEN_W = 12,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned BLEN_W = $clog2(DEPTH) + 1
) (
    input  logic [LEN_W-1:0]  remain,
    output logic [BLEN_W-1:0] blen,
    output logic              last
);
    // burst size is the smaller of the remaining count and the buffer depth
    always_comb begin
        last = (remain <= LEN_W'(DEPTH));
        if (last) blen = BLEN_W'(remain);
        else      blen = BLEN_W'(DEPTH);
    end
endmodule

// File: rtl/aux_stage_buf.sv
module aux_stage_buf #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] ent_w [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [7:0] ent_q;
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(e)) ent_q <= wdata;
        end
        assign ent_w[e] = ent_q;
    end

    assign rdata = ent_w[ridx];
endmodule

// File: rtl/aux_ms_timer.sv
module aux_ms_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = !clr && tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick && !expired) cnt_q <= cnt_q + CNT_W'(1);
    end

    // R6
    tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q < limit);
endmodule

// File: rtl/aux_burst_xfer.sv
module aux_burst_xfer
    import aux_xfer_pkg::*;
#(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned TRIES   = 10,
    parameter int unsigned EN_MS   = 20,
    parameter int unsigned RPLY_MS = 10,
    parameter int unsigned STAT_W  = 4,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned BLEN_W = IDX_W + 1,
    localparam int unsigned TRY_W  = $clog2(TRIES + 1),
    localparam int unsigned TMR_W  = $clog2((EN_MS > RPLY_MS ? EN_MS : RPLY_MS) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              xfer_done,
    output logic              xfer_err,
    output logic              ch_buf_clr,
    output logic [7:0]        ch_addr_lo,
    output logic [7:0]        ch_addr_mid,
    output logic [3:0]        ch_addr_hi,
    output logic [IDX_W+3:0]  ch_cmd,
    output logic              ch_buf_we,
    output logic [IDX_W-1:0]  ch_buf_idx,
    output logic [7:0]        ch_buf_wdata,
    input  logic [7:0]        ch_buf_rdata,
    output logic              ch_start,
    input  logic              ch_busy,
    input  logic              ch_reply,
    output logic              ch_reply_clr,
    input  logic              ch_err,
    output logic              ch_err_clr,
    input  logic [STAT_W-1:0] ch_status
);
    xfer_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              wr_q;
    logic              err_q;
    logic [TRY_W-1:0]  tries_q;
    logic [BLEN_W-1:0] idx_q;

    logic [BLEN_W-1:0] blen;
    logic              last_burst;
    logic              last_idx;
    logic [IDX_W-1:0]  blen_m1;
    logic              tmr_clr;
    logic              tmr_exp;
    logic [TMR_W-1:0]  tmr_limit;
    logic              stage_we;
    logic [7:0]        stage_rdata;
    logic              fail_now;
    logic              pass_now;
    logic              give_up;

    // ---------------- sub-blocks ----------------
    aux_chunk_calc #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_chunk (
        .remain (remain_q),
        .blen   (blen),
        .last   (last_burst)
    );

    assign stage_we = (state_q == S_GATHER) && wr_valid;

    aux_stage_buf #(.DEPTH(DEPTH)) u_stage (
        .clk   (clk),
        .we    (stage_we),
        .widx  (idx_q[IDX_W-1:0]),
        .wdata (wr_data),
        .ridx  (idx_q[IDX_W-1:0]),
        .rdata (stage_rdata)
    );

    // timer runs only while waiting; restarts when busy drops
    assign tmr_clr = !((state_q == S_WAIT_EN && ch_busy) || state_q == S_WAIT_REPLY);
    assign tmr_limit = (state_q == S_WAIT_EN) ? TMR_W'(EN_MS) : TMR_W'(RPLY_MS);

    aux_ms_timer #(.CNT_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tick_ms),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    // ---------------- attempt verdict ----------------
    assign blen_m1  = IDX_W'(blen - BLEN_W'(1));
    assign last_idx = (idx_q == blen - BLEN_W'(1));

    always_comb begin
        fail_now = 1'b0;
        pass_now = 1'b0;
        unique case (state_q)
            S_WAIT_EN:    fail_now = ch_busy && tmr_exp;
            S_WAIT_REPLY: fail_now = !ch_reply && tmr_exp;
            S_JUDGE: begin
                if (ch_err)                   fail_now = 1'b1;
                else if (ch_status != '0)     fail_now = 1'b1;
                else                          pass_now = 1'b1;
            end
            default: ;
        endcase
    end

    assign give_up = fail_now && (tries_q == TRY_W'(TRIES - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_len == '0)  state_d = S_FINISH;
                    else if (req_write) state_d = S_GATHER;
                    else                state_d = S_CLEAR;
                end
            end
            S_GATHER:     if (wr_valid && last_idx) state_d = S_CLEAR;
            S_CLEAR:      state_d = wr_q ? S_LOAD : S_START;
            S_LOAD:       if (last_idx) state_d = S_START;
            S_START:      state_d = S_WAIT_EN;
            S_WAIT_EN: begin
                if (!ch_busy)     state_d = S_WAIT_REPLY;
                else if (fail_now) state_d = give_up ? S_FINISH : S_CLEAR;
            end
            S_WAIT_REPLY: begin
                if (ch_reply)      state_d = S_JUDGE;
                else if (fail_now) state_d = give_up ? S_FINISH : S_CLEAR;
            end
            S_JUDGE: begin
                if (fail_now)      state_d = give_up ? S_FINISH : S_CLEAR;
                else if (pass_now) state_d = wr_q ? S_ADVANCE : S_UNLOAD;
            end
            S_UNLOAD:     if (rd_ready && last_idx) state_d = S_ADVANCE;
            S_ADVANCE: begin
                if (last_burst) state_d = S_FINISH;
                else            state_d = wr_q ? S_GATHER : S_CLEAR;
            end
            S_FINISH:     state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            wr_q     <= 1'b0;
            err_q    <= 1'b0;
            tries_q  <= '0;
            idx_q    <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                addr_q   <= req_addr;
                remain_q <= req_len;
                wr_q     <= req_write;
                err_q    <= 1'b0;
                tries_q  <= '0;
                idx_q    <= '0;
            end
            if (state_q == S_GATHER && wr_valid)
                idx_q <= last_idx ? '0 : idx_q + BLEN_W'(1);
            if (state_q == S_CLEAR)
                idx_q <= '0;
            if (state_q == S_LOAD)
                idx_q <= idx_q + BLEN_W'(1);
            if (fail_now) begin
                if (give_up) err_q   <= 1'b1;
                else         tries_q <= tries_q + TRY_W'(1);
            end
            if (pass_now)
                idx_q <= '0;
            if (state_q == S_UNLOAD && rd_ready)
                idx_q <= idx_q + BLEN_W'(1);
            if (state_q == S_ADVANCE) begin
                addr_q   <= addr_q + ADDR_W'(blen);
                remain_q <= remain_q - LEN_W'(blen);
                tries_q  <= '0;
                idx_q    <= '0;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready    = 1'b0;
        wr_ready     = 1'b0;
        rd_valid     = 1'b0;
        xfer_done    = 1'b0;
        xfer_err     = 1'b0;
        ch_buf_clr   = 1'b0;
        ch_buf_we    = 1'b0;
        ch_start     = 1'b0;
        ch_reply_clr = 1'b0;
        ch_err_clr   = 1'b0;
        unique case (state_q)
            S_IDLE:       req_ready = 1'b1;
            S_GATHER:     wr_ready = 1'b1;
            S_CLEAR:      ch_buf_clr = 1'b1;
            S_LOAD:       ch_buf_we = 1'b1;
            S_START:      ch_start = 1'b1;
            S_WAIT_REPLY: ch_reply_clr = ch_reply;
            S_JUDGE:      ch_err_clr = ch_err;
            S_UNLOAD:     rd_valid = 1'b1;
            S_FINISH: begin
                xfer_done = 1'b1;
                xfer_err  = err_q;
            end
            default: ;
        endcase
    end

    assign rd_data      = ch_buf_rdata;
    assign ch_buf_idx   = idx_q[IDX_W-1:0];
    assign ch_buf_wdata = stage_rdata;
    assign ch_addr_lo   = addr_q[7:0];
    assign ch_addr_mid  = addr_q[15:8];
    assign ch_addr_hi   = addr_q[19:16];
    assign ch_cmd       = {blen_m1, 1'b1, 2'b00, !wr_q};

    // ---------------- assertions ----------------
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R12
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (xfer_done && !xfer_err));

    // R11
    reply_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_reply_clr |-> ch_reply);

    // R8
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_err_clr |=> (ch_buf_clr || xfer_done));

    // R10
    tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TRY_W'(TRIES));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(ch_buf_idx)));

    // R6
    en_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_EN && ch_busy && tmr_exp) |=> (ch_buf_clr || xfer_done));

    // R7
    reply_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_REPLY && !ch_reply && tmr_exp) |=> (ch_buf_clr || xfer_done));
endmodule

// File: tb/test_aux_burst_xfer.sv
`timescale 1ns/100ps
module test_aux_burst_xfer;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        xfer_done, xfer_err;
    logic        ch_buf_clr, ch_buf_we, ch_start, ch_reply_clr, ch_err_clr;
    logic [7:0]  ch_addr_lo, ch_addr_mid, ch_cmd, ch_buf_wdata, ch_buf_rdata;
    logic [3:0]  ch_addr_hi, ch_buf_idx, ch_status;
    logic        ch_busy, ch_reply, ch_err;

    aux_burst_xfer i_aux_burst_xfer (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .xfer_done(xfer_done), .xfer_err(xfer_err),
        .ch_buf_clr(ch_buf_clr), .ch_addr_lo(ch_addr_lo), .ch_addr_mid(ch_addr_mid),
        .ch_addr_hi(ch_addr_hi), .ch_cmd(ch_cmd), .ch_buf_we(ch_buf_we),
        .ch_buf_idx(ch_buf_idx), .ch_buf_wdata(ch_buf_wdata), .ch_buf_rdata(ch_buf_rdata),
        .ch_start(ch_start), .ch_busy(ch_busy), .ch_reply(ch_reply),
        .ch_reply_clr(ch_reply_clr), .ch_err(ch_err), .ch_err_clr(ch_err_clr),
        .ch_status(ch_status)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int start_cnt = 0;
    bit done_seen = 0;
    bit bp_on = 0;

    // expected attempt records and data
    logic [19:0]  ex_addr[$];
    logic [7:0]   ex_cmd[$];
    logic [127:0] ex_buf[$];
    logic [7:0]   ex_rd[$];
    logic         ex_err = 1'b0;
    logic [7:0]   wq[$];
    int           plan_q[$];
    int           oc_q[$];

    task automatic chk(input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [19:0] a, input int i);
        logic [19:0] s;
        s = a + 20'(i);
        return s[7:0] ^ {s[11:8], s[19:16]} ^ 8'h5A;
    endfunction

    // ---------------- channel model ----------------
    // outcome codes: 0 ok, 1 busy stuck, 2 no reply, 3 error flag, 4 bad status
    logic [7:0]  mbuf [16];
    logic        m_busy, m_reply, m_err;
    logic [3:0]  m_stat;
    int          m_phase, m_cnt, m_oc, m_len, t_oc;
    logic [19:0] m_addr;
    logic        m_rd;

    assign ch_busy      = m_busy;
    assign ch_reply     = m_reply;
    assign ch_err       = m_err;
    assign ch_status    = m_stat;
    assign ch_buf_rdata = mbuf[ch_buf_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mbuf[i] <= 8'h00;
            m_busy <= 0; m_reply <= 0; m_err <= 0; m_stat <= 0;
            m_phase <= 0; m_cnt <= 0; m_oc <= 0; m_len <= 0; m_addr <= 0; m_rd <= 0;
        end else begin
            if (ch_buf_we) mbuf[ch_buf_idx] <= ch_buf_wdata;
            if (ch_reply_clr) m_reply <= 0;
            if (ch_err_clr) m_err <= 0;
            if (ch_start) begin
                t_oc = (oc_q.size() > 0) ? oc_q.pop_front() : 0;
                m_oc <= t_oc;
                m_busy <= 1; m_phase <= 1; m_cnt <= 3;
                m_addr <= {ch_addr_hi, ch_addr_mid, ch_addr_lo};
                m_rd <= ch_cmd[0];
                m_len <= int'(ch_cmd[7:4]) + 1;
            end else if (ch_buf_clr) begin
                for (int i = 0; i < 16; i++) mbuf[i] <= 8'h00;
                m_busy <= 0; m_stat <= 0; m_phase <= 0;
            end else begin
                case (m_phase)
                    1: if (m_oc != 1) begin
                        if (m_cnt == 0) begin m_busy <= 0; m_phase <= 2; m_cnt <= 4; end
                        else m_cnt <= m_cnt - 1;
                    end
                    2: if (m_oc != 2) begin
                        if (m_cnt == 0) begin
                            m_reply <= 1;
                            m_err <= (m_oc == 3);
                            m_stat <= (m_oc == 4) ? 4'h2 : 4'h0;
                            if (m_oc == 0 && m_rd)
                                for (int i = 0; i < 16; i++)
                                    if (i < m_len) mbuf[i] <= pat(m_addr, i);
                            m_phase <= 0;
                        end else m_cnt <= m_cnt - 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- per-clock monitor and stream drivers ----------------
    always @(negedge clk) begin
        logic [127:0] img;
        #1;
        cyc++;
        tick_ms = (cyc % 4 == 0);
        if (rst_n) begin
            if (ch_start) begin
                start_cnt++;
                if (ex_addr.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R10 unexpected start: actual=1 expected=0");
                end else begin
                    for (int i = 0; i < 16; i++) img[i*8 +: 8] = mbuf[i];
                    chk("R2", "address fields", {ch_addr_hi, ch_addr_mid, ch_addr_lo}, ex_addr.pop_front());
                    chk("R3", "command word", ch_cmd, ex_cmd.pop_front());
                    chk("R4", "buffer at start", img, ex_buf.pop_front());
                    chk("R11", "reply flag at start", m_reply, 1'b0);
                    chk("R8", "error flag at start", m_err, 1'b0);
                end
            end
            if (xfer_done) begin
                chk("R10", "xfer_err", xfer_err, ex_err);
                chk("R1", "attempts left at done", ex_addr.size(), 0);
                chk("R5", "read bytes left at done", ex_rd.size(), 0);
                done_seen = 1;
            end
            wr_valid = (wq.size() > 0);
            wr_data  = wr_valid ? wq[0] : 8'h00;
            if (wr_valid && wr_ready) void'(wq.pop_front());
            rd_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
            if (rd_valid && rd_ready) begin
                if (ex_rd.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R5 unexpected read byte: actual=%0h expected=none", rd_data);
                end else chk("R5", "rd_data", rd_data, ex_rd.pop_front());
            end
        end
    end

    // ---------------- reference and request driver ----------------
    task automatic run_xfer(input logic wr, input logic [19:0] a, input int len);
        int rem = len;
        int k = 0;
        int n_att = 0;
        int s0;
        logic [19:0] cur = a;
        bit abort = 0;
        ex_err = 1'b0;
        if (wr) for (int i = 0; i < len; i++) wq.push_back(8'(i * 13 + len));
        while (rem > 0 && !abort) begin
            int bl;
            int tries;
            bit ok;
            logic [127:0] img;
            bl = (rem > 16) ? 16 : rem;
            tries = 0; ok = 0; img = '0;
            if (wr) for (int i = 0; i < bl; i++) img[i*8 +: 8] = 8'((k + i) * 13 + len);
            while (!ok && tries < 10) begin
                int oc;
                oc = (plan_q.size() > 0) ? plan_q.pop_front() : 0;
                ex_addr.push_back(cur);
                ex_cmd.push_back({4'(bl - 1), 1'b1, 2'b00, !wr});
                ex_buf.push_back(img);
                oc_q.push_back(oc);
                n_att++;
                if (oc == 0) ok = 1; else tries++;
            end
            if (!ok) begin abort = 1; ex_err = 1'b1; end
            else if (!wr) for (int i = 0; i < bl; i++) ex_rd.push_back(pat(cur, i));
            cur = cur + 20'(bl); rem = rem - bl; k = k + bl;
        end
        s0 = start_cnt;
        @(negedge clk);
        chk("R13", "req_ready when idle", req_ready, 1'b1);
        req_valid = 1; req_write = wr; req_addr = a; req_len = 12'(len);
        @(negedge clk);
        req_valid = 0;
        if (len == 0) begin
            chk("R12", "done after zero-length accept", xfer_done, 1'b1);
            chk("R12", "no error on zero-length", xfer_err, 1'b0);
        end else chk("R13", "req_ready while busy", req_ready, 1'b0);
        while (!done_seen) @(negedge clk);
        done_seen = 0;
        #2;
        chk("R10", "attempt count", start_cnt - s0, n_att);
        wq.delete();
        oc_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #2;
        chk("R13", "reset req_ready", req_ready, 1'b1);
        chk("R13", "reset xfer_done", xfer_done, 1'b0);
        chk("R5", "reset rd_valid", rd_valid, 1'b0);
        chk("R4", "reset ch_start", ch_start, 1'b0);

        // R12: zero length
        run_xfer(1'b0, 20'h00100, 0);
        // R1 R3 R4: short write
        run_xfer(1'b1, 20'h12345, 5);
        // R1 R2: read across the top of the address space
        run_xfer(1'b0, 20'hFFFF8, 40);
        // R6 R7 R8 R9: every failure kind then success
        plan_q = '{1, 2, 3, 4, 0};
        run_xfer(1'b1, 20'h00400, 20);
        // R10: ten failures abort the request
        plan_q = '{4, 4, 4, 4, 4, 4, 4, 4, 4, 4};
        run_xfer(1'b0, 20'h0ABCD, 30);
        // R10: nine failures still succeed
        plan_q = '{3, 4, 3, 4, 3, 4, 3, 4, 4, 0};
        run_xfer(1'b1, 20'h00077, 3);
        // R5: backpressure on read stream with a retry
        bp_on = 1;
        plan_q = '{3, 0};
        run_xfer(1'b0, 20'h55555, 33);
        bp_on = 0;
        // R1: exactly one full burst
        run_xfer(1'b1, 20'h7FFF0, 16);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule